// File: doc/BRIEF.md
# Shader Instruction Fetch-Bind Stage

This block sits between a thread-group scheduler and the execution back end of a shader core. Each cycle it can take one runnable thread-group identifier. The group then passes through a fixed-length pipeline. One cycle after acceptance it is shown to an external PC register file. That file answers with the group's word-addressed program counter a fixed number of cycles later. The PC is looked up in a small direct-mapped instruction cache, and the stage emits a wave record holding the group, the instruction word and a retry flag.

A cache miss never stalls the pipeline. The group still leaves in its fixed output slot with retry raised. In the background the stage fetches the whole 16-word line over an AXI4 read burst. The scheduler must re-issue retried groups later. A flush input invalidates every line. After reset the stage clears its tag state one line per cycle and only then raises its ready output. From that point ready stays high for good.

Top module: `shader_fetch_bind`

## Requirements
- R1: After reset release `run_ready_o` stays low for exactly LINES cycles while every line is invalidated. During reset, `wave_valid_o` and `ar_valid_o` are low. Once `run_ready_o` is high it never drops again.
- R2: Each accepted group appears on the wave port exactly BIND_STAGES = PC_LAT+2 cycles after the cycle in which it was accepted. Groups are never reordered, dropped or duplicated.
- R3: `pc_grp_o` carries the accepted group in the cycle after acceptance. `pc_i` is used PC_LAT cycles after that.
- R4: On a hit, `wave_retry_o` is 0 and `wave_insn_o` is the memory word at word address `pc`, which is byte address 4*pc.
- R5: On a miss the wave is still emitted with valid 1 and retry 1. If no refill is running, a refill of the line holding the PC starts.
- R6: A refill read request has `ar_addr_o` = 4*(pc & ~15), which is 64-byte aligned. It has `ar_len_o` = 15, `ar_size_o` = 2 (4-byte beats) and `ar_burst_o` = 1 (incrementing). Valid and address hold steady until `ar_ready_i` is seen.
- R7: At most one refill is outstanding. A miss during a refill, whether to the same line or another line, starts no burst. A line that was missed while busy stays absent.
- R8: Beats are stored at word offsets 0 to 15 in order of arrival. The line becomes valid only after the beat with `r_last_i` is accepted. `r_ready_o` is high only while a burst is outstanding.
- R9: The cache is direct-mapped. The index is pc[6:4] for 8 lines, and the tag is the PC bits above it. Filling a line with another tag at the same index evicts the old one.
- R10: A one-cycle pulse on `flush_i` invalidates all lines at once, so the following lookups miss. `run_ready_o` is unaffected.
- R11: If `flush_i` pulses while a refill is outstanding, the line that refill completes is not made valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate the whole cache |
| run_valid_i | input | 1 | Runnable group offered |
| run_grp_i | input | $clog2(GROUPS) | Runnable group identifier |
| run_ready_o | output | 1 | Stage accepts groups |
| pc_grp_o | output | $clog2(GROUPS) | Group presented to the PC register file |
| pc_i | input | PC_W | Word-addressed PC, PC_LAT cycles after `pc_grp_o` |
| wave_valid_o | output | 1 | Wave record valid |
| wave_grp_o | output | $clog2(GROUPS) | Wave group |
| wave_insn_o | output | DATA_W | Instruction word; meaningless when retry is set |
| wave_retry_o | output | 1 | Miss: group must be re-issued |
| ar_valid_o | output | 1 | Read address valid |
| ar_ready_i | input | 1 | Read address ready |
| ar_addr_o | output | PC_W+2 | Read byte address |
| ar_len_o | output | 8 | Burst length minus one |
| ar_size_o | output | 3 | Beat size code |
| ar_burst_o | output | 2 | Burst type |
| r_valid_i | input | 1 | Read data valid |
| r_ready_o | output | 1 | Read data ready |
| r_data_i | input | DATA_W | Read data beat |
| r_last_i | input | 1 | Last beat of burst |

## Verification
The hardest case to reach from the ports is a flush that lands while a refill is in flight. The bench makes its memory responder wait several cycles before the first data beat. It pulses the flush once the retried wave has been seen, so the read request has already gone out. It then checks that a re-issue of the same PC still misses. Misses that arrive while busy are produced by issuing four groups back to back into one cold line, and by issuing two cold lines one cycle apart. The bench then counts read requests and checks which lines later hit. Before flushing, the bench changes the memory contents, so a stale hit shows up as a wrong instruction.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef enum logic [1:0] {RF_IDLE, RF_ADDR, RF_DATA} refill_state_e;
  localparam logic [1:0] AXI_BURST_INCR = 2'b01;
endpackage

// File: rtl/fb_group_pipe.sv
module fb_group_pipe #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned GRP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [GRP_W-1:0] in_grp_i,
  output logic [GRP_W-1:0] head_grp_o,
  output logic             tail_valid_o,
  output logic [GRP_W-1:0] tail_grp_o
);
  logic [DEPTH-1:0] vld_q;
  logic [GRP_W-1:0] grp_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int s = 0; s < DEPTH; s++) grp_q[s] <= '0;
    end else begin
      vld_q[0] <= in_valid_i;
      grp_q[0] <= in_grp_i;
      for (int s = 1; s < DEPTH; s++) begin
        vld_q[s] <= vld_q[s-1];
        grp_q[s] <= grp_q[s-1];
      end
    end
  end

  assign head_grp_o   = grp_q[0];
  assign tail_valid_o = vld_q[DEPTH-1];
  assign tail_grp_o   = grp_q[DEPTH-1];
endmodule

// File: rtl/fb_icache.sv
module fb_icache #(
  parameter int unsigned LINES      = 8,
  parameter int unsigned LINE_WORDS = 16,
  parameter int unsigned PC_W       = 30,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned OFF_W     = $clog2(LINE_WORDS),
  localparam int unsigned IDX_W     = $clog2(LINES),
  localparam int unsigned LINE_W    = PC_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [PC_W-1:0]   lk_pc_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              start_i,
  input  logic [LINE_W-1:0] start_line_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  word_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              commit_i,
  output logic              ready_o
);
  localparam int unsigned TAG_W = LINE_W - IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES*LINE_WORDS];
  logic [IDX_W-1:0]  sweep_q;
  logic              init_done_q;

  logic [IDX_W-1:0] lk_idx, st_idx;
  logic [TAG_W-1:0] lk_tag, st_tag;

  assign lk_idx = lk_pc_i[OFF_W +: IDX_W];
  assign lk_tag = lk_pc_i[PC_W-1 -: TAG_W];
  assign st_idx = start_line_i[IDX_W-1:0];
  assign st_tag = start_line_i[LINE_W-1 -: TAG_W];

  // valid bits: post-reset sweep, flush, fill start/commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q     <= '0;
      sweep_q     <= '0;
      init_done_q <= 1'b0;
    end else begin
      if (!init_done_q) begin
        valid_q[sweep_q] <= 1'b0;
        sweep_q          <= sweep_q + 1'b1;
        if (sweep_q == IDX_W'(LINES-1)) init_done_q <= 1'b1;
      end
      if (flush_i) begin
        valid_q <= '0;
      end else begin
        if (start_i)  valid_q[st_idx]     <= 1'b0;
        if (commit_i) valid_q[fill_idx_i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (start_i) tag_q[st_idx] <= st_tag;
    if (we_i)    data_q[{fill_idx_i, word_i}] <= wdata_i;
  end

  assign hit_o   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign data_o  = data_q[lk_pc_i[OFF_W+IDX_W-1:0]];
  assign ready_o = init_done_q;
endmodule

// File: rtl/fb_refill.sv
module fb_refill
  import fb_pkg::*;
#(
  parameter int unsigned PC_W       = 30,
  parameter int unsigned LINE_WORDS = 16,
  parameter int unsigned LINES      = 8,
  parameter int unsigned DATA_W     = 32,
  localparam int unsigned OFF_W     = $clog2(LINE_WORDS),
  localparam int unsigned IDX_W     = $clog2(LINES),
  localparam int unsigned LINE_W    = PC_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              miss_i,
  input  logic [LINE_W-1:0] miss_line_i,
  output logic              start_o,
  output logic [IDX_W-1:0]  fill_idx_o,
  output logic              we_o,
  output logic [OFF_W-1:0]  word_o,
  output logic              commit_o,
  output logic              ar_valid_o,
  input  logic              ar_ready_i,
  output logic [PC_W+1:0]   ar_addr_o,
  output logic [7:0]        ar_len_o,
  output logic [2:0]        ar_size_o,
  output logic [1:0]        ar_burst_o,
  input  logic              r_valid_i,
  output logic              r_ready_o,
  input  logic              r_last_i
);
  refill_state_e     state_q;
  logic [LINE_W-1:0] line_q;
  logic [OFF_W-1:0]  beat_q;
  logic              stale_q;
  logic              beat;

  assign start_o    = miss_i && (state_q == RF_IDLE);
  assign ar_valid_o = (state_q == RF_ADDR);
  assign ar_addr_o  = {line_q, (OFF_W+2)'(0)};
  assign ar_len_o   = 8'(LINE_WORDS - 1);
  assign ar_size_o  = 3'($clog2(DATA_W/8));
  assign ar_burst_o = AXI_BURST_INCR;
  assign r_ready_o  = (state_q == RF_DATA);
  assign beat       = r_valid_i && r_ready_o;
  assign we_o       = beat;
  assign word_o     = beat_q;
  assign fill_idx_o = line_q[IDX_W-1:0];
  // a flush seen during the burst leaves the line invalid
  assign commit_o   = beat && r_last_i && !stale_q && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RF_IDLE;
      line_q  <= '0;
      beat_q  <= '0;
      stale_q <= 1'b0;
    end else begin
      unique case (state_q)
        RF_IDLE: if (start_o) begin
          line_q  <= miss_line_i;
          stale_q <= 1'b0;
          state_q <= RF_ADDR;
        end
        RF_ADDR: begin
          if (flush_i) stale_q <= 1'b1;
          if (ar_ready_i) begin
            beat_q  <= '0;
            state_q <= RF_DATA;
          end
        end
        RF_DATA: begin
          if (flush_i) stale_q <= 1'b1;
          if (beat) begin
            beat_q <= beat_q + 1'b1;
            if (r_last_i) state_q <= RF_IDLE;
          end
        end
        default: state_q <= RF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shader_fetch_bind.sv
module shader_fetch_bind #(
  parameter int unsigned GROUPS     = 64,
  parameter int unsigned PC_LAT     = 3,
  parameter int unsigned PC_W       = 30,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LINES      = 8,
  parameter int unsigned LINE_WORDS = 16,
  localparam int unsigned GRP_W     = $clog2(GROUPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              run_valid_i,
  input  logic [GRP_W-1:0]  run_grp_i,
  output logic              run_ready_o,
  output logic [GRP_W-1:0]  pc_grp_o,
  input  logic [PC_W-1:0]   pc_i,
  output logic              wave_valid_o,
  output logic [GRP_W-1:0]  wave_grp_o,
  output logic [DATA_W-1:0] wave_insn_o,
  output logic              wave_retry_o,
  output logic              ar_valid_o,
  input  logic              ar_ready_i,
  output logic [PC_W+1:0]   ar_addr_o,
  output logic [7:0]        ar_len_o,
  output logic [2:0]        ar_size_o,
  output logic [1:0]        ar_burst_o,
  input  logic              r_valid_i,
  output logic              r_ready_o,
  input  logic [DATA_W-1:0] r_data_i,
  input  logic              r_last_i
);
  localparam int unsigned OFF_W  = $clog2(LINE_WORDS);
  localparam int unsigned IDX_W  = $clog2(LINES);
  localparam int unsigned LINE_W = PC_W - OFF_W;

  logic              accept, lk_valid, hit, miss, start, we, commit;
  logic [GRP_W-1:0]  lk_grp;
  logic [DATA_W-1:0] lk_data;
  logic [IDX_W-1:0]  fill_idx;
  logic [OFF_W-1:0]  fill_word;

  assign accept = run_valid_i && run_ready_o;

  // one stage to the PC port, PC_LAT stages until the PC is back
  fb_group_pipe #(.DEPTH(PC_LAT+1), .GRP_W(GRP_W)) i_pipe (
    .clk_i, .rst_ni,
    .in_valid_i   (accept),
    .in_grp_i     (run_grp_i),
    .head_grp_o   (pc_grp_o),
    .tail_valid_o (lk_valid),
    .tail_grp_o   (lk_grp)
  );

  fb_icache #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .PC_W(PC_W), .DATA_W(DATA_W)) i_cache (
    .clk_i, .rst_ni, .flush_i,
    .lk_pc_i      (pc_i),
    .hit_o        (hit),
    .data_o       (lk_data),
    .start_i      (start),
    .start_line_i (pc_i[PC_W-1:OFF_W]),
    .fill_idx_i   (fill_idx),
    .we_i         (we),
    .word_i       (fill_word),
    .wdata_i      (r_data_i),
    .commit_i     (commit),
    .ready_o      (run_ready_o)
  );

  assign miss = lk_valid && !hit;

  fb_refill #(.PC_W(PC_W), .LINE_WORDS(LINE_WORDS), .LINES(LINES), .DATA_W(DATA_W)) i_refill (
    .clk_i, .rst_ni, .flush_i,
    .miss_i      (miss),
    .miss_line_i (pc_i[PC_W-1:OFF_W]),
    .start_o     (start),
    .fill_idx_o  (fill_idx),
    .we_o        (we),
    .word_o      (fill_word),
    .commit_o    (commit),
    .ar_valid_o, .ar_ready_i, .ar_addr_o, .ar_len_o, .ar_size_o, .ar_burst_o,
    .r_valid_i, .r_ready_o, .r_last_i
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_valid_o <= 1'b0;
      wave_grp_o   <= '0;
      wave_insn_o  <= '0;
      wave_retry_o <= 1'b0;
    end else begin
      wave_valid_o <= lk_valid;
      wave_grp_o   <= lk_grp;
      wave_insn_o  <= lk_data;
      wave_retry_o <= miss;
    end
  end

  logic unused_line;
  assign unused_line = ^LINE_W;
endmodule

// File: rtl/fb_checker.sv
module fb_checker #(
  parameter int unsigned GRP_W      = 6,
  parameter int unsigned PC_LAT     = 3,
  parameter int unsigned PC_W       = 30,
  parameter int unsigned LINE_WORDS = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_valid_i,
  input logic [GRP_W-1:0] run_grp_i,
  input logic             run_ready_o,
  input logic [GRP_W-1:0] pc_grp_o,
  input logic             wave_valid_o,
  input logic [GRP_W-1:0] wave_grp_o,
  input logic             ar_valid_o,
  input logic             ar_ready_i,
  input logic [PC_W+1:0]  ar_addr_o,
  input logic [7:0]       ar_len_o,
  input logic [2:0]       ar_size_o,
  input logic [1:0]       ar_burst_o,
  input logic             r_valid_i,
  input logic             r_ready_o,
  input logic             r_last_i
);
  localparam int unsigned STAGES = PC_LAT + 2;
  localparam int unsigned OFF_W  = $clog2(LINE_WORDS);

  logic [STAGES-1:0] sv_q;
  logic [GRP_W-1:0]  sg_q [STAGES];
  logic              busy_q;
  logic [OFF_W:0]    beats_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sv_q    <= '0;
      for (int s = 0; s < STAGES; s++) sg_q[s] <= '0;
      busy_q  <= 1'b0;
      beats_q <= '0;
    end else begin
      sv_q[0] <= run_valid_i && run_ready_o;
      sg_q[0] <= run_grp_i;
      for (int s = 1; s < STAGES; s++) begin
        sv_q[s] <= sv_q[s-1];
        sg_q[s] <= sg_q[s-1];
      end
      if (ar_valid_o && ar_ready_i) busy_q <= 1'b1;
      if (r_valid_i && r_ready_o) begin
        beats_q <= r_last_i ? '0 : beats_q + 1'b1;
        if (r_last_i) busy_q <= 1'b0;
      end
    end
  end

  a_r1_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_ready_o |=> run_ready_o);
  a_r2_wave_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wave_valid_o == sv_q[STAGES-1]);
  a_r2_wave_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wave_valid_o |-> wave_grp_o == sg_q[STAGES-1]);
  a_r3_pc_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sv_q[0] |-> pc_grp_o == sg_q[0]);
  a_r6_ar_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_valid_o |-> (ar_len_o == 8'(LINE_WORDS-1)) && (ar_size_o == 3'd2)
                   && (ar_burst_o == 2'b01) && (ar_addr_o[OFF_W+1:0] == '0));
  a_r6_ar_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_valid_o && !ar_ready_i |=> ar_valid_o && $stable(ar_addr_o));
  a_r7_single_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !ar_valid_o);
  a_r8_rready_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_ready_o |-> busy_q);
  a_r8_last_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_valid_i && r_ready_o && r_last_i |-> beats_q == (OFF_W+1)'(LINE_WORDS-1));
endmodule

bind shader_fetch_bind fb_checker #(
  .GRP_W(GRP_W), .PC_LAT(PC_LAT), .PC_W(PC_W), .LINE_WORDS(LINE_WORDS)
) i_fb_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_valid_i(run_valid_i), .run_grp_i(run_grp_i),
  .run_ready_o(run_ready_o), .pc_grp_o(pc_grp_o), .wave_valid_o(wave_valid_o),
  .wave_grp_o(wave_grp_o), .ar_valid_o(ar_valid_o), .ar_ready_i(ar_ready_i),
  .ar_addr_o(ar_addr_o), .ar_len_o(ar_len_o), .ar_size_o(ar_size_o),
  .ar_burst_o(ar_burst_o), .r_valid_i(r_valid_i), .r_ready_o(r_ready_o),
  .r_last_i(r_last_i)
);

// File: tb/test_shader_fetch_bind.sv
module test_shader_fetch_bind;
  localparam int CLK_PERIOD = 10;
  localparam int LINES      = 8;
  localparam int STAGES     = 5;
  localparam int HIT = 0, MISS = 1, ANY = 2;

  logic        clk_i = 0, rst_ni = 0, flush_i = 0;
  logic        run_valid_i = 0;
  logic [5:0]  run_grp_i = 0;
  logic        run_ready_o;
  logic [5:0]  pc_grp_o;
  logic [29:0] pc_i;
  logic        wave_valid_o, wave_retry_o;
  logic [5:0]  wave_grp_o;
  logic [31:0] wave_insn_o;
  logic        ar_valid_o, ar_ready_i;
  logic [31:0] ar_addr_o;
  logic [7:0]  ar_len_o;
  logic [2:0]  ar_size_o;
  logic [1:0]  ar_burst_o;
  logic        r_valid_i, r_ready_o, r_last_i;
  logic [31:0] r_data_i;

  shader_fetch_bind i_shader_fetch_bind (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0, ar_cnt = 0;
  logic [31:0] epoch = 0, last_ar_addr = 0;
  bit done = 0, ready_seen = 0;
  logic [29:0] pc_tab [64];
  logic [29:0] d1, d2;

  int          q_grp[$], q_exp[$], q_due[$];
  logic [29:0] q_pc[$];
  string       q_req[$];

  function automatic logic [31:0] mem_word(input logic [29:0] w);
    return (32'(w) * 32'h9E3779B1) ^ epoch;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk_i) cyc <= cyc + 1;

  // PC register file model: answer PC_LAT=3 cycles after the group is shown
  always @(posedge clk_i) begin
    d1   <= pc_tab[pc_grp_o];
    d2   <= d1;
    pc_i <= d2;
  end

  // memory responder
  initial begin
    ar_ready_i = 0; r_valid_i = 0; r_last_i = 0; r_data_i = 0;
    forever begin
      @(negedge clk_i);
      if (ar_valid_o) begin
        @(negedge clk_i);
        ar_ready_i = 1;
        last_ar_addr = ar_addr_o;
        check(ar_len_o == 8'd15 && ar_size_o == 3'd2 && ar_burst_o == 2'b01,
              "R6", "ar fields", {ar_len_o, ar_size_o, ar_burst_o}, {8'd15, 3'd2, 2'b01});
        @(negedge clk_i);
        ar_ready_i = 0;
        ar_cnt++;
        repeat (6) @(negedge clk_i);
        for (int b = 0; b < 16; b++) begin
          if (b % 5 == 4) begin
            r_valid_i = 0;
            @(negedge clk_i);
          end
          r_valid_i = 1;
          r_data_i  = mem_word(30'(last_ar_addr >> 2) + 30'(b));
          r_last_i  = (b == 15);
          while (!r_ready_o) @(negedge clk_i);
          @(negedge clk_i);
        end
        r_valid_i = 0; r_last_i = 0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (run_ready_o) ready_seen = 1;
      else if (ready_seen) check(0, "R1", "ready dropped", 0, 1);
      if (wave_valid_o) begin
        if (q_grp.size() == 0) begin
          check(0, "R2", "unexpected wave", wave_grp_o, 0);
        end else begin
          int g, e, d; logic [29:0] p; string r;
          g = q_grp.pop_front(); e = q_exp.pop_front(); d = q_due.pop_front();
          p = q_pc.pop_front(); r = q_req.pop_front();
          check(wave_grp_o == 6'(g), "R2", "group", wave_grp_o, g);
          check(cyc == d, "R2", "latency slot", cyc, d);
          if (e != ANY)
            check(wave_retry_o == (e == MISS), r, "retry", wave_retry_o, e);
          if (!wave_retry_o)
            check(wave_insn_o == mem_word(p), "R4", "insn", wave_insn_o, mem_word(p));
        end
      end
    end
  end

  task automatic issue(input int g, input logic [29:0] pc, input int exp, input string req);
    pc_tab[g] = pc;
    run_valid_i = 1; run_grp_i = 6'(g);
    q_grp.push_back(g); q_pc.push_back(pc); q_exp.push_back(exp);
    q_due.push_back(cyc + STAGES); q_req.push_back(req);
    @(negedge clk_i);
    run_valid_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "R2", "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int a0;
    for (int i = 0; i < 64; i++) pc_tab[i] = '0;
    idle(2);
    check(!run_ready_o && !wave_valid_o && !ar_valid_o, "R1", "reset state",
          {run_ready_o, wave_valid_o, ar_valid_o}, 0);
    rst_ni = 1;
    for (int k = 1; k <= LINES; k++) begin
      @(negedge clk_i);
      if (k >= LINES - 1)
        check(run_ready_o == (k == LINES), "R1", "init sweep ready", run_ready_o, k == LINES);
    end

    // R5 cold miss, then hit
    issue(5, 30'h100, MISS, "R5");
    idle(60);
    check(ar_cnt == 1, "R5", "one refill", ar_cnt, 1);
    check(last_ar_addr == 32'h400, "R6", "ar address", last_ar_addr, 32'h400);
    issue(5, 30'h103, HIT, "R4");
    idle(10);

    // R7/R8 back-to-back misses into one line
    a0 = ar_cnt;
    issue(1, 30'h200, MISS, "R7"); issue(2, 30'h20F, MISS, "R7");
    issue(3, 30'h205, MISS, "R7"); issue(4, 30'h200, MISS, "R7");
    idle(60);
    check(ar_cnt == a0 + 1, "R7", "single burst same line", ar_cnt, a0 + 1);
    issue(1, 30'h200, HIT, "R8"); issue(2, 30'h20F, HIT, "R8");
    issue(3, 30'h205, HIT, "R8"); issue(4, 30'h20A, HIT, "R8");
    idle(10);

    // R7 miss to another line while busy
    a0 = ar_cnt;
    issue(10, 30'h300, MISS, "R7"); issue(11, 30'h410, MISS, "R7");
    idle(60);
    check(ar_cnt == a0 + 1, "R7", "no second burst", ar_cnt, a0 + 1);
    issue(10, 30'h301, HIT, "R7");
    issue(11, 30'h411, MISS, "R7");
    idle(60);
    issue(11, 30'h412, HIT, "R7");
    idle(10);

    // R9 eviction on same index
    issue(20, 30'h500, MISS, "R9"); idle(60);
    issue(20, 30'h500, HIT, "R9");
    issue(21, 30'h580, MISS, "R9"); idle(60);
    issue(21, 30'h581, HIT, "R9");
    issue(20, 30'h500, MISS, "R9"); idle(60);
    issue(20, 30'h502, HIT, "R9");
    idle(10);

    // R10 flush with changed memory
    flush_i = 1; epoch = 32'hA5A5_0001;
    @(negedge clk_i); flush_i = 0;
    check(run_ready_o, "R10", "ready after flush", run_ready_o, 1);
    issue(20, 30'h502, MISS, "R10"); idle(60);
    issue(20, 30'h503, HIT, "R10");
    idle(10);

    // R11 flush during refill
    issue(30, 30'h700, MISS, "R11");
    idle(STAGES);
    flush_i = 1; @(negedge clk_i); flush_i = 0;
    idle(60);
    issue(30, 30'h700, MISS, "R11"); idle(60);
    issue(30, 30'h704, HIT, "R11");
    idle(10);

    // R2 random stream with gaps
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 4 == 0) idle(1);
      else begin
        int g;
        g = int'($urandom % 64);
        issue(g, 30'h800 + 30'((g * 37) & 255), ANY, "R2");
      end
    end
    idle(100);
    check(q_grp.size() == 0, "R2", "all waves emitted", q_grp.size(), 0);
    finish_run();
  end
endmodule